// File: doc/BRIEF.md
# Atomic Compare and Conditional Add Unit

This unit carries out one locked read-modify-write on a 64-bit memory word. It takes a command made of a word address, a comparand, an addend and a 4-bit condition selector. It reads the word under a held bus lock and subtracts the comparand from that word. The subtraction produces six arithmetic flags. The selected condition is then evaluated against those flags. The unit always writes back in the same locked sequence: the word plus the addend when the condition holds, and the unchanged word otherwise.

When it finishes, the unit returns the original memory word, which the caller places into the comparand register, together with the flags. An address that is not aligned to eight bytes is rejected with a fault, and no memory traffic takes place. Address translation, caching and instruction decode are handled outside the unit.

Top module: `cca_unit`

## Requirements
- R1: After reset `cmd_ready` is 1 and `res_valid`, `res_fault`, `res_flags`, `mem_lock`, `mem_rd_req` and `mem_wr_req` are 0. A command is taken only on a cycle where both `cmd_valid` and `cmd_ready` are 1. `cmd_ready` stays 0 from the cycle after acceptance until the cycle after `res_valid`.
- R2: If any of `cmd_addr[2:0]` is nonzero, the unit makes no read and no write. It raises `res_valid` with `res_fault`=1 in the cycle after acceptance, and `res_flags` keeps its previous value.
- R3: `mem_lock` is 1 whenever `mem_rd_req` or `mem_wr_req` is 1. It stays 1 from the read request until the write is acknowledged, and it is 0 in the `res_valid` cycle.
- R4: `res_flags` bits are [5]=overflow, [4]=sign, [3]=zero, [2]=aux, [1]=parity and [0]=carry. They come from the subtraction memory minus `cmd_cmp`. Carry is the unsigned borrow. Aux is the borrow out of bit 3. Parity is 1 when the low byte of the difference holds an even number of ones. Overflow marks a signed overflow.
- R5: `cmd_cond` encodings: 0 overflow, 1 no overflow, 2 carry, 3 no carry, 4 zero, 5 not zero, 6 carry or zero, 7 neither carry nor zero, 8 sign, 9 no sign, 10 parity, 11 no parity, 12 sign≠overflow, 13 sign=overflow, 14 zero or sign≠overflow, 15 not zero and sign=overflow.
- R6: The written value is memory + `cmd_add` (modulo 2^64) when the selected condition is true, and the original memory word when it is false.
- R7: Every aligned command makes exactly one read followed by exactly one write, even when the condition is false.
- R8: `res_old` equals the memory word that was read. `res_valid` lasts exactly one cycle.
- R9: `mem_addr` equals the command address during the read and the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_addr | input | 48 | Byte address of the memory word |
| cmd_cmp | input | 64 | Comparand (first register operand) |
| cmd_add | input | 64 | Addend (second register operand) |
| cmd_cond | input | 4 | Condition selector |
| mem_lock | output | 1 | Bus lock held |
| mem_addr | output | 48 | Memory address |
| mem_rd_req | output | 1 | Read request |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read data |
| mem_wr_req | output | 1 | Write request |
| mem_wr_data | output | 64 | Write data |
| mem_wr_ack | input | 1 | Write accepted |
| res_valid | output | 1 | Result pulse |
| res_old | output | 64 | Original memory word |
| res_flags | output | 6 | Flags from the compare |
| res_fault | output | 1 | Alignment fault |

## Verification
Two events can land in the same cycle: the flag computation and the condition decision made from those flags, and the capture of read data that happens on the very edge that opens the write. Both are driven by memory responders with zero to three cycles of latency. Zero-latency responses put the read-data capture and the switch to writing in back-to-back cycles. The comparand is set equal to the memory value, or picked to produce borrow, sign or overflow on purpose, so that every condition code sits right at its decision point. Each result is judged against a bench model of the subtraction. The bench also checks the written value, the count of reads and writes, and how the lock behaves.

// File: rtl/cca_pkg.sv
// Shared types for the compare and conditional add unit.
// Assumes a 4-bit condition selector whose low bit inverts the sense.
package cca_pkg;
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } cca_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } cca_state_e;
endpackage

// File: rtl/cca_flags.sv
// Flag generator: subtracts subtrahend from minuend and derives the six
// arithmetic flags. Purely combinational; assumes W >= 8.
module cca_flags
    import cca_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output cca_flags_t   flags
);
    logic [W:0]   ext;
    logic [W-1:0] diff;

    assign ext  = {1'b0, minuend} - {1'b0, subtrahend};
    assign diff = ext[W-1:0];

    // Derive each flag from the extended difference.
    always_comb begin
        flags.cry = ext[W];
        flags.zro = (diff == '0);
        flags.sgn = diff[W-1];
        flags.par = ~^diff[7:0];
        flags.aux = minuend[4] ^ subtrahend[4] ^ diff[4];
        flags.ovf = (minuend[W-1] != subtrahend[W-1]) && (diff[W-1] != minuend[W-1]);
    end
endmodule

// File: rtl/cca_cond.sv
// Condition evaluator: code[3:1] picks a base predicate, code[0] inverts it.
module cca_cond
    import cca_pkg::*;
(
    input  cca_flags_t flags,
    input  logic [3:0] code,
    output logic       taken
);
    logic base;

    // Select the base predicate for the pair of codes.
    always_comb begin
        unique case (code[3:1])
            3'd0:    base = flags.ovf;
            3'd1:    base = flags.cry;
            3'd2:    base = flags.zro;
            3'd3:    base = flags.cry | flags.zro;
            3'd4:    base = flags.sgn;
            3'd5:    base = flags.par;
            3'd6:    base = flags.sgn ^ flags.ovf;
            default: base = flags.zro | (flags.sgn ^ flags.ovf);
        endcase
    end

    assign taken = base ^ code[0];
endmodule

// File: rtl/cca_ctrl.sv
// Sequencer for one locked read-modify-write. Assumes the memory side
// answers each request with a single-cycle valid or ack.
module cca_ctrl
    import cca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic misalign,
    input  logic rd_valid,
    input  logic wr_ack,
    output logic ready,
    output logic in_read,
    output logic in_write,
    output logic done
);
    cca_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = misalign ? ST_DONE : ST_READ;
            ST_READ:  if (rd_valid) state_d = ST_WRITE;
            ST_WRITE: if (wr_ack) state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign ready    = (state_q == ST_IDLE);
    assign in_read  = (state_q == ST_READ);
    assign in_write = (state_q == ST_WRITE);
    assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/cca_unit.sv
// Atomic compare and conditional add unit. Latches a command, reads the
// word under lock, compares, writes back either the sum or the original,
// and reports the original word and flags. Assumes a naturally aligned
// DATA_W-bit word; misaligned addresses fault without memory access.
module cca_unit
    import cca_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_cmp,
    input  logic [DATA_W-1:0] cmd_add,
    input  logic [3:0]        cmd_cond,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_req,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_old,
    output logic [5:0]        res_flags,
    output logic              res_fault
);
    localparam int ALIGN_W = $clog2(DATA_W / 8);

    logic              start, misalign, in_read, in_write, done, taken;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] cmp_q, add_q, old_q, wdata_q;
    logic [3:0]        cond_q;
    logic              fault_q;
    cca_flags_t        flags_now, flags_q;

    assign start    = cmd_valid & cmd_ready;
    assign misalign = |cmd_addr[ALIGN_W-1:0];

    cca_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .misalign (misalign),
        .rd_valid (mem_rd_valid),
        .wr_ack   (mem_wr_ack),
        .ready    (cmd_ready),
        .in_read  (in_read),
        .in_write (in_write),
        .done     (done)
    );

    cca_flags #(.W(DATA_W)) u_flags (
        .minuend    (mem_rd_data),
        .subtrahend (cmp_q),
        .flags      (flags_now)
    );

    cca_cond u_cond (
        .flags (flags_now),
        .code  (cond_q),
        .taken (taken)
    );

    // Capture the command operands on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cmp_q   <= '0;
            add_q   <= '0;
            cond_q  <= '0;
            fault_q <= 1'b0;
        end else if (start) begin
            addr_q  <= cmd_addr;
            cmp_q   <= cmd_cmp;
            add_q   <= cmd_add;
            cond_q  <= cmd_cond;
            fault_q <= misalign;
        end
    end

    // Capture read data, flags and the chosen write value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q   <= '0;
            wdata_q <= '0;
            flags_q <= '0;
        end else if (in_read && mem_rd_valid) begin
            old_q   <= mem_rd_data;
            wdata_q <= taken ? (mem_rd_data + add_q) : mem_rd_data;
            flags_q <= flags_now;
        end
    end

    assign mem_lock    = in_read | in_write;
    assign mem_rd_req  = in_read;
    assign mem_wr_req  = in_write;
    assign mem_addr    = addr_q;
    assign mem_wr_data = wdata_q;
    assign res_valid   = done;
    assign res_old     = old_q;
    assign res_flags   = flags_q;
    assign res_fault   = fault_q;
endmodule

// File: rtl/cca_unit_chk.sv
// Protocol checker for cca_unit, attached by bind below.
module cca_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       misalign,
    input logic       mem_lock,
    input logic       mem_rd_req,
    input logic       mem_rd_valid,
    input logic       mem_wr_req,
    input logic       res_valid,
    input logic       res_fault,
    input logic [5:0] res_flags
);
    p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || mem_lock) |-> !cmd_ready);

    p_fault_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && misalign) |=>
            (res_valid && res_fault && !mem_rd_req && !mem_wr_req));

    p_fault_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> $stable(res_flags));

    p_lock_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> mem_lock);

    p_lock_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_lock);

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mem_lock);

    p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_req) |-> $past(mem_rd_valid));

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

bind cca_unit cca_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .misalign     (|cmd_addr[2:0]),
    .mem_lock     (mem_lock),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_req   (mem_wr_req),
    .res_valid    (res_valid),
    .res_fault    (res_fault),
    .res_flags    (res_flags)
);

// File: tb/cca_unit_test.sv
module cca_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [47:0] cmd_addr = '0;
    logic [63:0] cmd_cmp = '0;
    logic [63:0] cmd_add = '0;
    logic [3:0]  cmd_cond = '0;
    logic        mem_lock;
    logic [47:0] mem_addr;
    logic        mem_rd_req;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [63:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;
    logic        res_valid;
    logic [63:0] res_old;
    logic [5:0]  res_flags;
    logic        res_fault;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [63:0] mem [8];
    logic [5:0]  prev_flags = '0;

    always #10 clk = ~clk;

    cca_unit uut (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_flags(input logic [63:0] m, input logic [63:0] c);
        logic [63:0] d;
        logic o, s, z, a, p, cy;
        d  = m - c;
        cy = (m < c);
        z  = (d == 64'd0);
        s  = d[63];
        a  = (m[3:0] < c[3:0]);
        p  = ($countones(d[7:0]) % 2) == 0;
        o  = (m[63] != c[63]) && (d[63] != m[63]);
        return {o, s, z, a, p, cy};
    endfunction

    function automatic logic ref_cond(input logic [5:0] f, input logic [3:0] cc);
        logic o, s, z, p, cy;
        o = f[5]; s = f[4]; z = f[3]; p = f[1]; cy = f[0];
        case (cc)
            4'd0:  return o;
            4'd1:  return !o;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return z;
            4'd5:  return !z;
            4'd6:  return cy || z;
            4'd7:  return !cy && !z;
            4'd8:  return s;
            4'd9:  return !s;
            4'd10: return p;
            4'd11: return !p;
            4'd12: return s != o;
            4'd13: return s == o;
            4'd14: return z || (s != o);
            default: return !z && (s == o);
        endcase
    endfunction

    task automatic run_op(input logic [47:0] addr, input logic [63:0] cmpv,
                          input logic [63:0] addv, input logic [3:0] cc, input int lat);
        int idx, nrd, nwr, cyc, wcnt;
        logic [63:0] m0, expw, got_w;
        logic [5:0] ef;
        logic isfault, done, lock_ok, busy_ok, addr_ok;
        idx = int'(addr[5:3]);
        m0 = mem[idx];
        isfault = |addr[2:0];
        ef = ref_flags(m0, cmpv);
        expw = ref_cond(ef, cc) ? m0 + addv : m0;
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R1 ready before command", {63'd0, cmd_ready}, 64'd1);
        cmd_valid = 1'b1; cmd_addr = addr; cmd_cmp = cmpv; cmd_add = addv; cmd_cond = cc;
        @(negedge clk);
        cmd_valid = 1'b0;
        done = 0; nrd = 0; nwr = 0; cyc = 0; wcnt = 0; got_w = '0;
        lock_ok = 1; busy_ok = 1; addr_ok = 1;
        while (!done && cyc < 100) begin
            if (res_valid) begin
                done = 1;
            end else begin
                if (cmd_ready) busy_ok = 0;
                if ((mem_rd_req || mem_wr_req) && !mem_lock) lock_ok = 0;
                if ((mem_rd_req || mem_wr_req) && mem_addr != addr) addr_ok = 0;
                if (mem_rd_req) begin
                    if (wcnt == lat) begin
                        mem_rd_valid = 1'b1; mem_rd_data = mem[idx]; nrd++; wcnt = 0;
                    end else wcnt++;
                end
                if (mem_wr_req) begin
                    if (wcnt == lat) begin
                        mem_wr_ack = 1'b1; got_w = mem_wr_data; mem[idx] = got_w; nwr++; wcnt = 0;
                    end else wcnt++;
                end
                @(negedge clk);
                mem_rd_valid = 1'b0; mem_wr_ack = 1'b0;
                cyc++;
            end
        end
        chk(done, "R1 result produced", {63'd0, done}, 64'd1);
        chk(busy_ok, "R1 ready low while busy", {63'd0, busy_ok}, 64'd1);
        chk(res_fault === isfault, "R2 fault bit", {63'd0, res_fault}, {63'd0, isfault});
        chk(mem_lock === 1'b0, "R3 lock released at result", {63'd0, mem_lock}, 64'd0);
        if (isfault) begin
            chk(nrd == 0 && nwr == 0, "R2 no memory access on fault", 64'(nrd + nwr), 64'd0);
            chk(cyc == 0, "R2 fault result one cycle after accept", 64'(cyc), 64'd0);
            chk(res_flags === prev_flags, "R2 flags unchanged on fault", {58'd0, res_flags}, {58'd0, prev_flags});
        end else begin
            chk(nrd == 1 && nwr == 1, "R7 one read and one write", 64'(nrd * 16 + nwr), 64'd17);
            chk(got_w === expw, "R6 write value", got_w, expw);
            chk(res_old === m0, "R8 old value returned", res_old, m0);
            chk(res_flags === ef, "R4 flags", {58'd0, res_flags}, {58'd0, ef});
            chk(lock_ok, "R3 lock held across read and write", {63'd0, lock_ok}, 64'd1);
            chk(addr_ok, "R9 memory address", {63'd0, addr_ok}, 64'd1);
            prev_flags = ef;
        end
        @(negedge clk);
        chk(res_valid === 1'b0, "R8 single-cycle result", {63'd0, res_valid}, 64'd0);
        chk(cmd_ready === 1'b1, "R1 ready after result", {63'd0, cmd_ready}, 64'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) mem[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready === 1'b1, "R1 reset ready", {63'd0, cmd_ready}, 64'd1);
        chk({res_valid, res_fault, mem_lock, mem_rd_req, mem_wr_req} === 5'd0, "R1 reset outputs",
            {59'd0, res_valid, res_fault, mem_lock, mem_rd_req, mem_wr_req}, 64'd0);
        chk(res_flags === 6'd0, "R1 reset flags", {58'd0, res_flags}, 64'd0);

        // R2 fault first, flags must stay at reset value
        run_op(48'h1001, 64'd5, 64'd1, 4'd4, 0);
        // Directed R4/R5 corners
        mem[1] = 64'd100;
        run_op(48'h0008, 64'd100, 64'd7, 4'd4, 0);        // zero -> taken
        mem[2] = 64'h8000_0000_0000_0000;
        run_op(48'h0010, 64'd1, 64'd3, 4'd0, 1);          // overflow
        mem[3] = 64'd0;
        run_op(48'h0018, 64'd1, 64'd9, 4'd2, 2);          // borrow
        mem[4] = 64'hFFFF_FFFF_FFFF_FFFF;
        run_op(48'h0020, 64'd0, 64'd2, 4'd3, 0);          // R6 sum wraps
        mem[5] = 64'd10;
        run_op(48'h0028, 64'd10, 64'd5, 4'd5, 3);         // R7 not taken still writes
        for (int a = 1; a < 8; a++) run_op(48'h0100 | 48'(a), 64'd0, 64'd1, 4'd15, 0);
        // All sixteen codes, each at an equal and an unequal compare
        for (int c = 0; c < 16; c++) begin
            run_op(48'h0030, mem[6], 64'd11, 4'(c), c % 4);
            run_op(48'h0038, {$urandom, $urandom}, 64'd13, 4'(c), 0);
        end
        // Constrained random mix
        for (int n = 0; n < 150; n++) begin
            logic [47:0] ad;
            logic [63:0] cv;
            int sel;
            ad = {$urandom, $urandom} & 48'h0000_0000_003F;
            if (($urandom % 8) != 0) ad[2:0] = 3'd0;
            sel = int'($urandom % 4);
            case (sel)
                0: cv = mem[ad[5:3]];
                1: cv = mem[ad[5:3]] + 64'd1;
                2: cv = {1'b1, 63'(({$urandom, $urandom}))};
                default: cv = {$urandom, $urandom};
            endcase
            run_op(ad, cv, {$urandom, $urandom}, 4'($urandom), int'($urandom % 4));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule